// File: doc/BRIEF.md
# Flash Block Lock Protection Controller

This block holds the protection state of every block in a small banked flash array and rules on each program or erase request before the array's own algorithm may begin. A decoded lock command names a block and one of three actions: lock, unlock or lock-down. A hardware protect pin decides whether locked-down blocks are frozen. A program or erase start is granted only if the target block is open for writing and the program-supply indication is valid at that moment. The grant then stays held until the array reports that the operation is done.

Each block holds two state bits, `{down, lock}`. The `lock` bit decides whether writing is allowed. The `down` bit records that a lock-down command has been applied, and only reset clears it. While the protect pin is low, a block whose `down` bit is set ignores every command. While the pin is high, such a block follows lock and unlock commands again, but it stays marked as locked down. Any block's state can be read at any time through a status index.

Top module: `flash_lock_ctrl`

## Requirements
- R1: While `rst_ni` is low, every block's status reads 01, both grants are low, `op_deny_o` is low and `prot_err_o` is low.
- R2: Command codes are 00 none, 01 lock, 10 unlock, 11 lock-down. On a block that is not frozen, lock sets status bit 0 and unlock clears it. The new status can be read from the cycle after the command, and other blocks are unchanged.
- R3: Lock-down sets status to 11. After that, bit 1 of that block reads 1 until reset, whatever commands follow.
- R4: While `wprot_i` is low, a block whose status bit 1 is set ignores lock, unlock and lock-down commands.
- R5: While `wprot_i` is high, a block whose status bit 1 is set follows lock (to 11) and unlock (to 10). When its bit 0 is clear, program and erase starts to it may be granted.
- R6: A start to a block with status bit 0 clear, with `vpp_ok_i` high, raises the matching grant in the next cycle. The grant holds until the cycle after `op_done_i` is sampled high.
- R7: A start to a block with status bit 0 set gives a one-cycle `op_deny_o` pulse in the next cycle, sets `prot_err_o` and raises no grant.
- R8: A start while `vpp_ok_i` is low is denied as in R7, whatever the block's status.
- R9: `vpp_ok_i` is sampled only in the start cycle. Later changes to it leave a held grant unchanged.
- R10: While a grant is held, lock commands and further starts are ignored. A command that arrives in the same cycle as a start is also ignored.
- R11: `prot_err_o` stays set until reset or until a later start is granted.
- R12: When program and erase starts arrive in the same cycle, only the program start is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; forces every block to locked |
| wprot_i | input | 1 | Protect pin; low freezes blocks that are locked down |
| vpp_ok_i | input | 1 | Program-supply level is above the lockout threshold |
| cmd_valid_i | input | 1 | Lock command strobe |
| cmd_op_i | input | 2 | Command code: 01 lock, 10 unlock, 11 lock-down |
| cmd_blk_i | input | BLK_W | Block addressed by the command |
| prog_start_i | input | 1 | Program start request |
| erase_start_i | input | 1 | Erase start request |
| op_blk_i | input | BLK_W | Block addressed by the start request |
| op_done_i | input | 1 | The running operation has finished |
| prog_grant_o | output | 1 | Program permitted; held while running |
| erase_grant_o | output | 1 | Erase permitted; held while running |
| op_deny_o | output | 1 | One-cycle pulse when a start is refused |
| prot_err_o | output | 1 | Sticky protection-error flag |
| stat_blk_i | input | BLK_W | Block whose status is shown |
| stat_o | output | 2 | Status `{down, lock}` of the selected block |

## Verification
On every cycle, the assertions check the reset values, that at most one grant is high, that a grant is held until done and released right after it, and that a refused supply level always leads to a deny. They also check that a frozen locked-down block and a block seen during a running operation keep their status, and that the down bit and the error flag are sticky. Only the bench's scenarios can show the full command sequences. These include unlocking a locked-down block once the protect pin is raised, ignoring a supply drop after a grant, discarding commands issued during an operation, and the program-over-erase choice when both arrive together.

// File: rtl/flp_pkg.sv
package flp_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_LOCK   = 2'b01,
        CMD_UNLOCK = 2'b10,
        CMD_LDOWN  = 2'b11
    } lk_cmd_e;

    typedef struct packed {
        logic down;
        logic lock;
    } blk_st_t;

    localparam blk_st_t BLK_ST_RESET = '{down: 1'b0, lock: 1'b1};

    typedef struct packed {
        logic busy;
        logic is_erase;
        logic deny;
        logic err;
    } op_st_t;

    localparam op_st_t OP_ST_RESET = '{busy: 1'b0, is_erase: 1'b0, deny: 1'b0, err: 1'b0};

endpackage

// File: rtl/flp_block_cell.sv
module flp_block_cell
    import flp_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    hit_i,
    input  lk_cmd_e cmd_i,
    input  logic    wprot_i,
    output blk_st_t state_o
);

    blk_st_t st_d, st_q;
    logic    frozen;

    always_comb begin
        st_d   = st_q;
        frozen = st_q.down && !wprot_i;
        if (hit_i && !frozen) begin
            unique case (cmd_i)
                CMD_LOCK:   st_d.lock = 1'b1;
                CMD_UNLOCK: st_d.lock = 1'b0;
                CMD_LDOWN: begin
                    st_d.lock = 1'b1;
                    st_d.down = 1'b1;
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= BLK_ST_RESET;
        else         st_q <= st_d;
    end

    assign state_o = st_q;

endmodule

// File: rtl/flp_op_arbiter.sv
module flp_op_arbiter
    import flp_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic prog_start_i,
    input  logic erase_start_i,
    input  logic blk_open_i,
    input  logic vpp_ok_i,
    input  logic op_done_i,
    output logic busy_o,
    output logic prog_grant_o,
    output logic erase_grant_o,
    output logic deny_o,
    output logic err_o
);

    op_st_t st_d, st_q;
    logic   take;
    logic   allow;

    always_comb begin
        st_d      = st_q;
        st_d.deny = 1'b0;
        take      = (prog_start_i || erase_start_i) && !st_q.busy;
        allow     = blk_open_i && vpp_ok_i;
        if (take) begin
            st_d.err  = !allow;
            st_d.deny = !allow;
            st_d.busy = allow;
            st_d.is_erase = !prog_start_i;
        end else if (st_q.busy && op_done_i) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= OP_ST_RESET;
        else         st_q <= st_d;
    end

    assign busy_o        = st_q.busy;
    assign prog_grant_o  = st_q.busy && !st_q.is_erase;
    assign erase_grant_o = st_q.busy && st_q.is_erase;
    assign deny_o        = st_q.deny;
    assign err_o         = st_q.err;

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
    import flp_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wprot_i,
    input  logic             vpp_ok_i,
    input  logic             cmd_valid_i,
    input  logic [1:0]       cmd_op_i,
    input  logic [BLK_W-1:0] cmd_blk_i,
    input  logic             prog_start_i,
    input  logic             erase_start_i,
    input  logic [BLK_W-1:0] op_blk_i,
    input  logic             op_done_i,
    output logic             prog_grant_o,
    output logic             erase_grant_o,
    output logic             op_deny_o,
    output logic             prot_err_o,
    input  logic [BLK_W-1:0] stat_blk_i,
    output logic [1:0]       stat_o
);

    localparam int SPAN = 1 << BLK_W;

    blk_st_t blk_st [SPAN];
    logic    busy;
    logic    cmd_take;
    logic    op_open;

    assign cmd_take = cmd_valid_i && !busy && !prog_start_i && !erase_start_i;

    for (genvar i = 0; i < SPAN; i++) begin : g_blk
        if (i < NUM_BLOCKS) begin : g_real
            flp_block_cell u_cell (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .hit_i   (cmd_take && (cmd_blk_i == BLK_W'(i))),
                .cmd_i   (lk_cmd_e'(cmd_op_i)),
                .wprot_i (wprot_i),
                .state_o (blk_st[i])
            );
        end else begin : g_pad
            assign blk_st[i] = BLK_ST_RESET;
        end
    end

    assign op_open = !blk_st[op_blk_i].lock;
    assign stat_o  = blk_st[stat_blk_i];

    flp_op_arbiter u_arb (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .prog_start_i  (prog_start_i),
        .erase_start_i (erase_start_i),
        .blk_open_i    (op_open),
        .vpp_ok_i      (vpp_ok_i),
        .op_done_i     (op_done_i),
        .busy_o        (busy),
        .prog_grant_o  (prog_grant_o),
        .erase_grant_o (erase_grant_o),
        .deny_o        (op_deny_o),
        .err_o         (prot_err_o)
    );

endmodule

// File: rtl/flash_lock_ctrl_chk.sv
module flash_lock_ctrl_chk #(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_W      = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wprot_i,
    input logic             vpp_ok_i,
    input logic             cmd_valid_i,
    input logic [1:0]       cmd_op_i,
    input logic [BLK_W-1:0] cmd_blk_i,
    input logic             prog_start_i,
    input logic             erase_start_i,
    input logic [BLK_W-1:0] op_blk_i,
    input logic             op_done_i,
    input logic             prog_grant_o,
    input logic             erase_grant_o,
    input logic             op_deny_o,
    input logic             prot_err_o,
    input logic [BLK_W-1:0] stat_blk_i,
    input logic [1:0]       stat_o
);

    logic any_grant;
    logic any_start;
    assign any_grant = prog_grant_o || erase_grant_o;
    assign any_start = prog_start_i || erase_start_i;

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (stat_o == 2'b01 && !any_grant && !op_deny_o && !prot_err_o));

    // R12
    grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({prog_grant_o, erase_grant_o}));

    // R7
    deny_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(op_deny_o && any_grant));

    // R9
    grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (any_grant && !op_done_i) |=> ($stable(prog_grant_o) && $stable(erase_grant_o)));

    // R6
    grant_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (any_grant && op_done_i) |=> !any_grant);

    // R8
    vpp_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (any_start && !vpp_ok_i && !any_grant) |=> (op_deny_o && !any_grant));

    // R11
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prot_err_o && !any_start) |=> prot_err_o);

    // R3
    down_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_o[1] |=> (stat_o[1] || stat_blk_i != $past(stat_blk_i)));

    // R4
    frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wprot_i && stat_o[1]) |=> (stat_o == $past(stat_o) || stat_blk_i != $past(stat_blk_i)));

    // R10
    busy_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_grant |=> (stat_o == $past(stat_o) || stat_blk_i != $past(stat_blk_i)));

endmodule

bind flash_lock_ctrl flash_lock_ctrl_chk #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_chk (.*);

// File: tb/flash_lock_ctrl_test.sv
module flash_lock_ctrl_test;

    localparam int NB = 8;
    localparam int BW = 3;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          wprot_i = 1'b1;
    logic          vpp_ok_i = 1'b1;
    logic          cmd_valid_i = 1'b0;
    logic [1:0]    cmd_op_i = 2'b00;
    logic [BW-1:0] cmd_blk_i = '0;
    logic          prog_start_i = 1'b0;
    logic          erase_start_i = 1'b0;
    logic [BW-1:0] op_blk_i = '0;
    logic          op_done_i = 1'b0;
    logic          prog_grant_o, erase_grant_o, op_deny_o, prot_err_o;
    logic [BW-1:0] stat_blk_i = '0;
    logic [1:0]    stat_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk_i = ~clk_i;

    flash_lock_ctrl #(.NUM_BLOCKS(NB), .BLK_W(BW)) uut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input int blk, output logic [1:0] v);
        stat_blk_i = BW'(blk);
        #1;
        v = stat_o;
    endtask

    task automatic cmd(input logic [1:0] op, input int blk);
        @(negedge clk_i);
        cmd_valid_i = 1'b1;
        cmd_op_i    = op;
        cmd_blk_i   = BW'(blk);
        @(negedge clk_i);
        cmd_valid_i = 1'b0;
        cmd_op_i    = 2'b00;
    endtask

    task automatic start(input logic p, input logic e, input int blk);
        @(negedge clk_i);
        prog_start_i  = p;
        erase_start_i = e;
        op_blk_i      = BW'(blk);
        @(negedge clk_i);
        prog_start_i  = 1'b0;
        erase_start_i = 1'b0;
    endtask

    task automatic finish_op();
        op_done_i = 1'b1;
        @(negedge clk_i);
        op_done_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [1:0] v;
        for (int b = 0; b < NB; b++) begin
            rd(b, v);
            chk("R1 status", 8'(v), 8'h1);
        end
        chk("R1 grants", {6'd0, prog_grant_o, erase_grant_o}, 8'h0);
        chk("R1 deny/err", {6'd0, op_deny_o, prot_err_o}, 8'h0);
    endtask

    task automatic t_lock_unlock();
        logic [1:0] v;
        cmd(2'b10, 2);
        rd(2, v); chk("R2 unlock", 8'(v), 8'h0);
        rd(3, v); chk("R2 neighbour", 8'(v), 8'h1);
        cmd(2'b01, 2);
        rd(2, v); chk("R2 lock", 8'(v), 8'h1);
        cmd(2'b00, 2);
        rd(2, v); chk("R2 none", 8'(v), 8'h1);
        cmd(2'b10, 2);
        rd(2, v); chk("R2 unlock again", 8'(v), 8'h0);
    endtask

    task automatic t_grant();
        start(1'b1, 1'b0, 2);
        chk("R6 prog grant", {6'd0, prog_grant_o, erase_grant_o}, 8'h2);
        chk("R6 no deny", 8'(op_deny_o), 8'h0);
        vpp_ok_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk_i);
            chk("R9 grant held", 8'(prog_grant_o), 8'h1);
        end
        finish_op();
        chk("R6 released", 8'(prog_grant_o), 8'h0);
        vpp_ok_i = 1'b1;
    endtask

    task automatic t_deny_locked();
        start(1'b0, 1'b1, 3);
        chk("R7 deny", 8'(op_deny_o), 8'h1);
        chk("R7 no grant", {6'd0, prog_grant_o, erase_grant_o}, 8'h0);
        chk("R7 err", 8'(prot_err_o), 8'h1);
        @(negedge clk_i);
        chk("R7 deny pulse ends", 8'(op_deny_o), 8'h0);
        chk("R11 err held", 8'(prot_err_o), 8'h1);
    endtask

    task automatic t_vpp_low();
        vpp_ok_i = 1'b0;
        start(1'b1, 1'b0, 2);
        chk("R8 deny low supply", 8'(op_deny_o), 8'h1);
        chk("R8 no grant", 8'(prog_grant_o), 8'h0);
        vpp_ok_i = 1'b1;
        start(1'b0, 1'b1, 2);
        chk("R11 err cleared on grant", 8'(prot_err_o), 8'h0);
        chk("R6 erase grant", {6'd0, prog_grant_o, erase_grant_o}, 8'h1);
        finish_op();
    endtask

    task automatic t_busy_ignore();
        logic [1:0] v;
        start(1'b0, 1'b1, 2);
        cmd(2'b01, 2);
        cmd(2'b10, 3);
        start(1'b1, 1'b0, 2);
        chk("R10 second start ignored", {6'd0, prog_grant_o, erase_grant_o}, 8'h1);
        finish_op();
        rd(2, v); chk("R10 blk2 unchanged", 8'(v), 8'h0);
        rd(3, v); chk("R10 blk3 unchanged", 8'(v), 8'h1);
        @(negedge clk_i);
        cmd_valid_i = 1'b1; cmd_op_i = 2'b01; cmd_blk_i = 3'd2;
        prog_start_i = 1'b1; op_blk_i = 3'd2;
        @(negedge clk_i);
        cmd_valid_i = 1'b0; cmd_op_i = 2'b00; prog_start_i = 1'b0;
        rd(2, v); chk("R10 cmd with start ignored", 8'(v), 8'h0);
        finish_op();
    endtask

    task automatic t_both();
        start(1'b1, 1'b1, 2);
        chk("R12 program wins", {6'd0, prog_grant_o, erase_grant_o}, 8'h2);
        finish_op();
    endtask

    task automatic t_lockdown();
        logic [1:0] v;
        wprot_i = 1'b0;
        cmd(2'b11, 4);
        rd(4, v); chk("R3 lock-down", 8'(v), 8'h3);
        cmd(2'b10, 4);
        rd(4, v); chk("R4 unlock refused", 8'(v), 8'h3);
        wprot_i = 1'b1;
        cmd(2'b10, 4);
        rd(4, v); chk("R5 unlock overridden", 8'(v), 8'h2);
        start(1'b1, 1'b0, 4);
        chk("R5 grant on down block", 8'(prog_grant_o), 8'h1);
        finish_op();
        wprot_i = 1'b0;
        cmd(2'b01, 4);
        rd(4, v); chk("R4 lock refused", 8'(v), 8'h2);
        wprot_i = 1'b1;
        cmd(2'b01, 4);
        rd(4, v); chk("R5 relock", 8'(v), 8'h3);
        cmd(2'b10, 4);
        cmd(2'b01, 4);
        rd(4, v); chk("R3 down bit kept", 8'(v), 8'h3);
        @(negedge clk_i);
        rst_ni = 1'b0;
        @(negedge clk_i);
        rd(4, v); chk("R1 reset clears down", 8'(v), 8'h1);
        rd(2, v); chk("R1 reset relocks", 8'(v), 8'h1);
        rst_ni = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_lock_unlock();
        t_grant();
        t_deny_locked();
        t_vpp_low();
        t_busy_ignore();
        t_both();
        t_lockdown();
        repeat (2) @(negedge clk_i);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule